// File: doc/BRIEF.md
# NAND Sector Hamming ECC Corrector

This block decides what to do with a NAND sector once its parity has been recomputed. For every 256-byte sector it receives two 22-bit codes. One is the code read back from the spare area, and the other is the code recomputed over the data that was just read. The block XORs the two codes into a syndrome. From the syndrome it sorts the sector into one of four cases: clean, a fault in the stored parity bytes themselves, a single data bit that can be repaired, or damage that cannot be repaired. For a repairable sector it reports where the bad bit is.

A wide mode handles a 512-byte unit as two back-to-back sectors. Each sector has its own code and its own result, and the error flag covers both. The classification is pipelined and accepts a new pair of codes on every clock.

A small streaming port sits beside the classifier. Each data byte read from the buffer passes through it. The byte at the failing location comes out with the bad bit inverted, so a read-modify-write pass over the buffer repairs the sector. The port is valid/ready. An input byte is accepted when `fix_in_valid` and `fix_in_ready` are both high on a rising edge. `fix_in_ready` is high whenever the single output register is empty or is being drained in the same cycle. An output byte that is held back stays unchanged until it is taken.

Top module: `nand_ecc_fix`

## Requirements
- R1: Sector h uses bits [22h+21:22h] of `calc_code` and `stored_code`. Within each 22-bit code, bits 10:0 are the parity word and bits 21:11 are the complement parity word. The failing location of sector h is reported on `fail_loc[11h+10:11h]`.
- R2: `done` pulses for exactly one cycle, on the second rising edge after the edge that samples `start`. `status` and `fail_loc` update together with that pulse and hold until the next one. After reset, `done`, `status`, `fail_loc` and `fix_out_valid` are all zero.
- R3: A sector is reported clean (status 00, location 0) in any of these cases: the syndrome (calculated XOR stored) is zero, the calculated code is all zeros, or the stored code is all zeros.
- R4: A sector whose syndrome has exactly one bit set is reported as a parity-field fault (status 01), with location 0.
- R5: A sector is reported as correctable (status 10) when the syndrome has exactly 11 bits set and every parity bit differs from its complement partner, that is syndrome[10:0] XOR syndrome[21:11] = 0x7FF. Its location is then syndrome[10:0], where the byte index is location[10:3] and the bit index is location[2:0].
- R6: Any other syndrome pattern is reported as uncorrectable (status 11), with location 0.
- R7: When `wide_mode` is low at `start`, only sector 0 is examined. Sector 1 then reports status 00 and location 0, whatever codes it was given.
- R8: `any_err` is high exactly when at least one sector currently reports status 01 or 11.
- R9: `fix_in_addr[8]` selects the sector and `fix_in_addr[7:0]` selects the byte within it. If, at the moment of acceptance, that sector's status is 10 and the byte index matches its location[10:3], the accepted byte comes out with bit location[2:0] inverted. Every other byte comes out unchanged.
- R10: `fix_in_ready` equals NOT `fix_out_valid` OR `fix_out_ready`. Each accepted byte produces exactly one output byte, in order. An output that is not taken keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Sample the codes and begin a classification |
| wide_mode | input | 1 | 1: both sectors (512 bytes); 0: sector 0 only |
| calc_code | input | 44 | Recomputed codes, sector h at bits 22h+21:22h |
| stored_code | input | 44 | Codes read from the spare area, same layout |
| done | output | 1 | One-cycle pulse when new results are valid |
| status | output | 4 | Per-sector class, sector h at bits 2h+1:2h |
| fail_loc | output | 22 | Per-sector failing location, sector h at bits 11h+10:11h |
| any_err | output | 1 | Some sector is a parity-field fault or uncorrectable |
| fix_in_valid | input | 1 | Data byte offered for repair |
| fix_in_ready | output | 1 | Repair port can accept a byte |
| fix_in_addr | input | 9 | Sector select (bit 8) and byte index (bits 7:0) |
| fix_in_byte | input | 8 | Byte as read from the buffer |
| fix_out_valid | output | 1 | Repaired byte available |
| fix_out_ready | input | 1 | Consumer takes the repaired byte |
| fix_out_byte | output | 8 | Byte after optional bit flip |

## Verification
The bench targets several corner cases, each with a distinct failure:
- Single-bit faults at the two extreme locations, 0x000 and 0x7FF. A design that mishandled the first would see only a complement word changing; one that mishandled the second would see a location whose top bit falls outside the byte range.
- A syndrome with eleven bits set whose parity/complement pairs do not all differ. This must be reported as uncorrectable; a corrector that only counts bits would "fix" a wrong byte.
- Codes that are all zeros but disagree with the other code. These must be reported clean, so a design missing that rule would report false faults on erased pages.
- Narrow mode with deliberately corrupted sector-1 codes. This exposes a design that leaks the idle sector into its status or its error flag.
- Back-to-back starts and a randomly stalled output on the repair port. These catch results that land one cycle early or late, bytes lost or duplicated under back-pressure, and bit flips applied to the neighbouring byte or to the other sector.

// File: rtl/nand_ecc_pkg.sv
`timescale 1ns/1ps
package nand_ecc_pkg;

  // Per-sector classification, encoding fixed by the brief.
  typedef enum logic [1:0] {
    ST_CLEAN    = 2'b00,
    ST_CODE_ERR = 2'b01,
    ST_FIXED    = 2'b10,
    ST_FATAL    = 2'b11
  } ecc_status_e;

endpackage

// File: rtl/ecc_popcount.sv
`timescale 1ns/1ps
// Balanced adder tree counting the set bits of a vector.
module ecc_popcount #(
  parameter int W = 22
) (
  input  logic [W-1:0]             vec,
  output logic [$clog2(W+1)-1:0]   count
);
  localparam int CW     = $clog2(W+1);
  localparam int LVLS   = (W > 1) ? $clog2(W) : 0;
  localparam int LEAVES = 1 << LVLS;

  genvar l, j;
  for (l = 0; l <= LVLS; l++) begin : g_lvl
    localparam int N = LEAVES >> l;
    logic [CW-1:0] s [N];
    for (j = 0; j < N; j++) begin : g_node
      if (l == 0) begin : g_leaf
        if (j < W) begin : g_bit
          assign s[j] = CW'(vec[j]);
        end else begin : g_pad
          assign s[j] = '0;
        end
      end else begin : g_sum
        assign s[j] = g_lvl[l-1].s[2*j] + g_lvl[l-1].s[2*j+1];
      end
    end
  end

  assign count = g_lvl[LVLS].s[0];

endmodule

// File: rtl/ecc_half_check.sv
`timescale 1ns/1ps
// Two-stage syndrome classifier for one sector.
// Stage 1 (on load): syndrome, all-zero screen, pair comparison.
// Stage 2 (on adv):  bit count and final class / location.
module ecc_half_check
  import nand_ecc_pkg::*;
#(
  parameter int PAR_W = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 adv,
  input  logic                 active,
  input  logic [2*PAR_W-1:0]   calc,
  input  logic [2*PAR_W-1:0]   stored,
  output ecc_status_e          status,
  output logic [PAR_W-1:0]     loc
);
  localparam int CODE_W = 2 * PAR_W;
  localparam int CNT_W  = $clog2(CODE_W + 1);

  logic [CODE_W-1:0] syn_d;
  logic [PAR_W-1:0]  calc_fold, stored_fold;
  logic              quiet_d, pairs_d;

  assign syn_d       = calc ^ stored;
  assign calc_fold   = calc[PAR_W-1:0]   ^ calc[CODE_W-1:PAR_W];
  assign stored_fold = stored[PAR_W-1:0] ^ stored[CODE_W-1:PAR_W];
  assign pairs_d     = ((calc_fold ^ stored_fold) == {PAR_W{1'b1}});
  assign quiet_d     = (syn_d == '0) || (calc == '0) || (stored == '0);

  logic [CODE_W-1:0] syn_q;
  logic              quiet_q, pairs_q, active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syn_q    <= '0;
      quiet_q  <= 1'b1;
      pairs_q  <= 1'b0;
      active_q <= 1'b0;
    end else if (load) begin
      syn_q    <= syn_d;
      quiet_q  <= quiet_d;
      pairs_q  <= pairs_d;
      active_q <= active;
    end
  end

  logic [CNT_W-1:0] ones;

  ecc_popcount #(.W(CODE_W)) u_count (
    .vec   (syn_q),
    .count (ones)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= ST_CLEAN;
      loc    <= '0;
    end else if (adv) begin
      loc <= '0;
      if (!active_q || quiet_q) begin
        status <= ST_CLEAN;
      end else if (ones == CNT_W'(1)) begin
        status <= ST_CODE_ERR;
      end else if ((ones == CNT_W'(PAR_W)) && pairs_q) begin
        status <= ST_FIXED;
        loc    <= syn_q[PAR_W-1:0];
      end else begin
        status <= ST_FATAL;
      end
    end
  end

  // R4: the adder tree agrees with a direct bit count of the syndrome.
  a_r4_tree_count: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (ones == CNT_W'($countones(syn_q))));

  // R5: a location is only ever reported for a correctable sector.
  a_r5_loc_only_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (status != ST_FIXED) |-> (loc == '0));

  // R7: a sector loaded while inactive reports clean once classified.
  a_r7_idle_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !active) |=> ##1 (status == ST_CLEAN));

endmodule

// File: rtl/nand_ecc_fix.sv
`timescale 1ns/1ps
module nand_ecc_fix
  import nand_ecc_pkg::*;
#(
  parameter int SECT_BYTES = 256,
  parameter int NSECT      = 2
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         start,
  input  logic                                         wide_mode,
  input  logic [NSECT*2*($clog2(SECT_BYTES)+3)-1:0]    calc_code,
  input  logic [NSECT*2*($clog2(SECT_BYTES)+3)-1:0]    stored_code,
  output logic                                         done,
  output logic [2*NSECT-1:0]                           status,
  output logic [NSECT*($clog2(SECT_BYTES)+3)-1:0]      fail_loc,
  output logic                                         any_err,
  input  logic                                         fix_in_valid,
  output logic                                         fix_in_ready,
  input  logic [$clog2(SECT_BYTES)+((NSECT>1)?$clog2(NSECT):1)-1:0] fix_in_addr,
  input  logic [7:0]                                   fix_in_byte,
  output logic                                         fix_out_valid,
  input  logic                                         fix_out_ready,
  output logic [7:0]                                   fix_out_byte
);
  localparam int BYTE_W = $clog2(SECT_BYTES);
  localparam int PAR_W  = BYTE_W + 3;
  localparam int CODE_W = 2 * PAR_W;
  localparam int SEL_W  = (NSECT > 1) ? $clog2(NSECT) : 1;
  localparam int ADDR_W = BYTE_W + SEL_W;

  // ---------------- classification pipeline ----------------
  logic v1_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      v1_q   <= start;
      done_q <= v1_q;
    end
  end

  assign done = done_q;

  ecc_status_e          st_arr   [NSECT];
  logic [PAR_W-1:0]     loc_arr  [NSECT];
  logic [NSECT-1:0]     err_bits;
  logic [7:0]           flip_arr [NSECT];
  logic [SEL_W-1:0]     addr_sel;
  logic [BYTE_W-1:0]    addr_byte;

  assign addr_sel  = fix_in_addr[ADDR_W-1:BYTE_W];
  assign addr_byte = fix_in_addr[BYTE_W-1:0];

  genvar h;
  for (h = 0; h < NSECT; h++) begin : g_sect
    logic act;
    if (h == 0) begin : g_first
      assign act = 1'b1;
    end else begin : g_rest
      assign act = wide_mode;
    end

    ecc_half_check #(.PAR_W(PAR_W)) u_half (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (start),
      .adv    (v1_q),
      .active (act),
      .calc   (calc_code[h*CODE_W +: CODE_W]),
      .stored (stored_code[h*CODE_W +: CODE_W]),
      .status (st_arr[h]),
      .loc    (loc_arr[h])
    );

    assign status[2*h +: 2]       = st_arr[h];
    assign fail_loc[h*PAR_W +: PAR_W] = loc_arr[h];
    assign err_bits[h] = (st_arr[h] == ST_CODE_ERR) || (st_arr[h] == ST_FATAL);

    logic hit;
    assign hit = (addr_sel == SEL_W'(h)) && (st_arr[h] == ST_FIXED) &&
                 (addr_byte == loc_arr[h][PAR_W-1:3]);
    assign flip_arr[h] = hit ? (8'd1 << loc_arr[h][2:0]) : 8'd0;
  end

  assign any_err = |err_bits;

  // ---------------- repair stream ----------------
  logic [7:0] flip_mask;

  always_comb begin
    flip_mask = 8'd0;
    for (int k = 0; k < NSECT; k++) begin
      flip_mask = flip_mask | flip_arr[k];
    end
  end

  assign fix_in_ready = !fix_out_valid || fix_out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fix_out_valid <= 1'b0;
      fix_out_byte  <= 8'd0;
    end else if (fix_in_valid && fix_in_ready) begin
      fix_out_valid <= 1'b1;
      fix_out_byte  <= fix_in_byte ^ flip_mask;
    end else if (fix_out_ready) begin
      fix_out_valid <= 1'b0;
    end
  end

  // R2: a result pulse always traces back to a start two edges earlier.
  a_r2_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 2));

  // R2: every start yields a result pulse two edges later.
  a_r2_start_done: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ##1 done);

  // R10: a stalled output byte is held unchanged.
  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_out_valid && !fix_out_ready) |=> (fix_out_valid && $stable(fix_out_byte)));

  // R8: the error flag never rises while every sector reports clean.
  a_r8_flag_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    any_err |-> (status != '0));

endmodule

// File: tb/nand_ecc_fix_tb_top.sv
`timescale 1ns/1ps
module nand_ecc_fix_tb_top;
  localparam int NS = 2;
  localparam int PW = 11;
  localparam int CW = 22;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic              start, wide_mode;
  logic [NS*CW-1:0]  calc_code, stored_code;
  logic              done, any_err;
  logic [2*NS-1:0]   status;
  logic [NS*PW-1:0]  fail_loc;
  logic              fix_in_valid, fix_in_ready;
  logic [8:0]        fix_in_addr;
  logic [7:0]        fix_in_byte;
  logic              fix_out_valid, fix_out_ready;
  logic [7:0]        fix_out_byte;

  nand_ecc_fix dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide_mode),
    .calc_code(calc_code), .stored_code(stored_code),
    .done(done), .status(status), .fail_loc(fail_loc), .any_err(any_err),
    .fix_in_valid(fix_in_valid), .fix_in_ready(fix_in_ready),
    .fix_in_addr(fix_in_addr), .fix_in_byte(fix_in_byte),
    .fix_out_valid(fix_out_valid), .fix_out_ready(fix_out_ready),
    .fix_out_byte(fix_out_byte)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int cyc = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: classify one sector from the requirements.
  function automatic void classify(input logic [21:0] c, input logic [21:0] s,
                                   output logic [1:0] st, output logic [10:0] loc);
    logic [21:0] syn;
    bit pairs;
    syn = c ^ s;
    pairs = 1;
    st = 2'd0;
    loc = 11'd0;
    for (int i = 0; i < 11; i++) if (syn[i] == syn[i+11]) pairs = 0;
    if (syn == 0 || c == 0 || s == 0) st = 2'd0;
    else if ($countones(syn) == 1) st = 2'd1;
    else if ($countones(syn) == 11 && pairs) begin st = 2'd2; loc = syn[10:0]; end
    else st = 2'd3;
  endfunction

  // Model state
  bit          p_v, p_wide, m_done, m_wide, m_fv;
  logic [1:0]  p_st [NS];
  logic [10:0] p_loc [NS];
  logic [1:0]  m_st [NS];
  logic [10:0] m_loc [NS];
  logic [7:0]  m_fb;
  logic [7:0]  msk;
  int          hs;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      p_v = 0; m_done = 0; m_fv = 0; m_fb = 0; m_wide = 0; p_wide = 0;
      for (int h = 0; h < NS; h++) begin
        p_st[h] = 0; p_loc[h] = 0; m_st[h] = 0; m_loc[h] = 0;
      end
    end else begin
      if (fix_in_valid && (!m_fv || fix_out_ready)) begin
        hs  = int'(fix_in_addr[8]);
        msk = 8'd0;
        if (m_st[hs] == 2'd2 && fix_in_addr[7:0] == m_loc[hs][10:3])
          msk = 8'd1 << m_loc[hs][2:0];
        m_fb = fix_in_byte ^ msk;
        m_fv = 1;
      end else if (fix_out_ready) begin
        m_fv = 0;
      end
      m_done = p_v;
      if (p_v) begin
        m_wide = p_wide;
        for (int h = 0; h < NS; h++) begin m_st[h] = p_st[h]; m_loc[h] = p_loc[h]; end
      end
      p_v = start;
      if (start) begin
        p_wide = wide_mode;
        for (int h = 0; h < NS; h++) begin
          if (h > 0 && !wide_mode) begin p_st[h] = 0; p_loc[h] = 0; end
          else classify(calc_code[h*CW +: CW], stored_code[h*CW +: CW], p_st[h], p_loc[h]);
        end
      end
    end
  end

  function automatic string stag(int h);
    if (h > 0 && !m_wide) return "R7 idle sector status";
    case (m_st[h])
      2'd0: return "R3 clean status";
      2'd1: return "R4 parity-field status";
      2'd2: return "R5 correctable status";
      default: return "R6 uncorrectable status";
    endcase
  endfunction

  // Compare on every falling edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 done pulse", {31'd0, done}, {31'd0, m_done});
      for (int h = 0; h < NS; h++) begin
        chk(stag(h), {30'd0, status[2*h +: 2]}, {30'd0, m_st[h]});
        chk(h == 1 ? "R1 sector 1 location" : "R5 sector 0 location",
            {21'd0, fail_loc[h*PW +: PW]}, {21'd0, m_loc[h]});
      end
      chk("R8 error flag", {31'd0, any_err},
          {31'd0, (m_st[0] == 2'd1 || m_st[0] == 2'd3 || m_st[1] == 2'd1 || m_st[1] == 2'd3)});
      chk("R10 input ready", {31'd0, fix_in_ready}, {31'd0, (!m_fv || fix_out_ready)});
      chk("R10 output valid", {31'd0, fix_out_valid}, {31'd0, m_fv});
      if (m_fv) chk("R9 repaired byte", {24'd0, fix_out_byte}, {24'd0, m_fb});
    end
  end

  bit rdy_rand = 0;
  always @(negedge clk) begin
    #1;
    fix_out_ready = rdy_rand ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  function automatic logic [21:0] mk_fix(logic [10:0] loc);
    return {~loc, loc};
  endfunction

  function automatic logic [21:0] rnz();
    logic [21:0] v;
    do v = 22'($urandom); while (v == 0);
    return v;
  endfunction

  // R1: sector h is packed at bits [22h+21:22h] of each code bus.
  task automatic eval(bit wide, logic [21:0] c0, logic [21:0] s0,
                      logic [21:0] c1, logic [21:0] s1);
    @(negedge clk); #1;
    start = 1; wide_mode = wide;
    calc_code = {c1, c0}; stored_code = {s1, s0};
  endtask

  task automatic idle(int n);
    @(negedge clk); #1;
    start = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(logic [8:0] a, logic [7:0] d);
    bit acc;
    @(negedge clk); #1;
    fix_in_valid = 1; fix_in_addr = a; fix_in_byte = d;
    forever begin
      #1 acc = fix_in_ready;
      @(negedge clk); #1;
      if (acc) break;
    end
    fix_in_valid = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [21:0] c, c1, t;
    logic [10:0] l0, l1;
    rst_n = 0; start = 0; wide_mode = 0; calc_code = 0; stored_code = 0;
    fix_in_valid = 0; fix_in_addr = 0; fix_in_byte = 0; fix_out_ready = 1;
    repeat (4) @(negedge clk);
    // R2 reset state
    chk("R2 reset done", {31'd0, done}, 32'd0);
    chk("R2 reset status", {28'd0, status}, 32'd0);
    chk("R2 reset location", {10'd0, fail_loc}, 32'd0);
    chk("R2 reset output valid", {31'd0, fix_out_valid}, 32'd0);
    #1 rst_n = 1;
    repeat (2) @(negedge clk);

    c = rnz();
    eval(0, c, c, 0, 0); idle(3);                          // R3 equal codes
    eval(0, 0, rnz(), 0, 0); idle(3);                      // R3 calc all zero
    eval(0, rnz(), 0, 0, 0); idle(3);                      // R3 stored all zero
    c = rnz(); eval(0, c, c ^ 22'(1 << 17), 0, 0); idle(3); // R4 one bit
    c = rnz(); c1 = rnz();
    eval(0, c, c ^ mk_fix(11'h2A5), c1, c1 ^ 22'h3); idle(3); // R5 + R7 idle sector
    c = rnz(); eval(0, c, c ^ mk_fix(11'h000), 0, 0); idle(3); // R5 loc 0
    c = rnz(); eval(0, c, c ^ mk_fix(11'h7FF), 0, 0); idle(3); // R5 loc max
    c = rnz(); eval(0, c, c ^ 22'h00_0003, 0, 0); idle(3);    // R6 two bits
    c = rnz(); eval(0, c, c ^ 22'h0F_803F, 0, 0); idle(3);    // R6 eleven bits, pairs not all differ

    // R9: repair pass over both sectors
    l0 = 11'h155; l1 = 11'h6C3;
    c = rnz(); c1 = rnz();
    eval(1, c, c ^ mk_fix(l0), c1, c1 ^ mk_fix(l1)); idle(3);
    send_byte({1'b0, l0[10:3]}, 8'hA5);
    send_byte({1'b0, l0[10:3] + 8'd1}, 8'hA5);
    send_byte({1'b1, l0[10:3]}, 8'h3C);
    send_byte({1'b1, l1[10:3]}, 8'h3C);
    send_byte({1'b0, l1[10:3]}, 8'h00);
    idle(3);

    // Back-to-back random starts
    for (int n = 0; n < 300; n++) begin
      logic [21:0] cc [2], ss [2];
      for (int h = 0; h < 2; h++) begin
        cc[h] = rnz();
        case ($urandom_range(0, 3))
          0: ss[h] = cc[h];
          1: ss[h] = cc[h] ^ 22'(1 << $urandom_range(0, 21));
          2: ss[h] = cc[h] ^ mk_fix(11'($urandom));
          default: ss[h] = 22'($urandom);
        endcase
      end
      eval(1'($urandom), cc[0], ss[0], cc[1], ss[1]);
    end
    idle(3);

    // R10: repair stream under random back-pressure
    l0 = 11'($urandom); l1 = 11'($urandom);
    c = rnz(); c1 = rnz();
    eval(1, c, c ^ mk_fix(l0), c1, c1 ^ mk_fix(l1)); idle(3);
    rdy_rand = 1;
    for (int n = 0; n < 400; n++) begin
      t = 22'($urandom);
      case (t[1:0])
        2'd0: send_byte({1'b0, l0[10:3]}, t[9:2]);
        2'd1: send_byte({1'b1, l1[10:3]}, t[9:2]);
        default: send_byte(9'(t[20:12]), t[9:2]);
      endcase
    end
    rdy_rand = 0;
    idle(10);
    finish_run();
  end

endmodule